// File: doc/BRIEF.md
# Receive Resource Ring Fetcher

This block loads the next receive buffer from a ring of buffer descriptors kept in external memory. A start pulse makes the block capture a 16-bit memory segment, four 16-bit ring pointers (base, limit, read and write) and a bus-width selector. It then reads the four entries of the descriptor that the read pointer addresses. Each read is a single 16-bit access over a request/acknowledge read port.

The entries give the buffer's start address and its remaining word count, each as a low and a high half. When all four entries have arrived, the block moves the read pointer past the descriptor. If the pointer reaches the ring limit, it returns to the ring base. The block flags exhaustion when the new read pointer meets the write pointer, which software owns. A one-cycle done pulse marks completion and clears the owner's fetch command.

Top module: `rx_resource_fetcher`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), busy, fetch_done, mem_req and pool_exhausted are 0, and all four buffer outputs and rd_ptr_new are 0.
- R2: If fetch_go is high at an edge while the block is idle, the block latches seg_upper, ring_base, ring_limit, ring_rd, ring_wr and wide_bus at that edge. From the next cycle, busy and mem_req are both high.
- R3: The block issues exactly four reads, for entry k = 0, 1, 2, 3 in that order. The address of entry k is the 32-bit sum {seg_upper, ring_rd} + k*2 when wide_bus is 0 (16-bit slots), or + k*4 when wide_bus is 1 (32-bit slots). A carry out of the low half propagates into the segment.
- R4: mem_req stays high with mem_addr unchanged until mem_ack is seen high at an edge. Each acknowledge completes exactly one entry.
- R5: mem_rdata at the acknowledge of entry 0 goes to buf_ptr_lo, entry 1 to buf_ptr_hi, entry 2 to buf_words_lo and entry 3 to buf_words_hi.
- R6: rd_ptr_new is ring_rd + 8 when wide_bus is 0, or ring_rd + 16 when wide_bus is 1, modulo 2^16.
- R7: If the advanced pointer equals ring_limit, rd_ptr_new is ring_base instead.
- R8: pool_exhausted is 1 exactly when the final rd_ptr_new equals ring_wr. It keeps this value until the next fetch completes.
- R9: fetch_done is high for one cycle, the cycle after the final acknowledge, and busy is still high in that cycle. In the following cycle busy is 0. The result outputs are valid when fetch_done is high.
- R10: A fetch_go during a fetch has no effect, and neither do changes to the pointer, segment or width inputs after the start edge. Addresses and results depend only on the values latched at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_go | input | 1 | Start a descriptor fetch |
| seg_upper | input | 16 | Upper 16 address bits of the ring |
| ring_base | input | 16 | Ring start pointer |
| ring_limit | input | 16 | Ring end pointer |
| ring_rd | input | 16 | Current read pointer |
| ring_wr | input | 16 | Software write pointer |
| wide_bus | input | 1 | 1: 32-bit entry slots, 0: 16-bit slots |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 16 | Read data |
| buf_ptr_lo | output | 16 | Buffer address, low half |
| buf_ptr_hi | output | 16 | Buffer address, high half |
| buf_words_lo | output | 16 | Buffer word count, low half |
| buf_words_hi | output | 16 | Buffer word count, high half |
| rd_ptr_new | output | 16 | Advanced (and possibly wrapped) read pointer |
| pool_exhausted | output | 1 | New read pointer equals write pointer |
| fetch_done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High from start to done |

## Verification
Random fetches mix both slot widths with random segments and pointers, and the memory acknowledges after a random delay of zero to three cycles. The wait cycles show that the address holds steady until acknowledged. Different data at every address shows that each entry lands in the correct output and that the entry stride follows the width mode.

Directed cases cover the following:
- a read pointer one descriptor short of the limit, which tells wrapping apart from plain advance;
- a write pointer placed on the wrapped value, which separates the exhaustion comparison from the limit comparison;
- a read pointer near 16'hFFFF, which tells 16-bit pointer roll-over apart from the 32-bit address carry into the segment.

Extra start pulses and scrambled inputs during a fetch show whether anything is sampled after the start edge.

// File: rtl/rrf_pkg.sv
// Package: shared types for the receive resource ring fetcher.
// Assumes: nothing beyond IEEE 1800-2017.
package rrf_pkg;
    typedef enum logic [1:0] {
        RRF_IDLE = 2'd0,
        RRF_READ = 2'd1,
        RRF_DONE = 2'd2
    } rrf_state_e;
endpackage

// File: rtl/rrf_addr_gen.sv
// Module: rrf_addr_gen
// Forms the byte address of one descriptor entry from the segment, the
// read pointer, the entry index and the slot width.
// Assumes: narrow slots are 2 bytes, wide slots are 4 bytes; the low half
// of a wide slot sits at the slot's first address.
module rrf_addr_gen #(
    parameter int PTR_W = 16,
    parameter int IDX_W = 2
) (
    input  logic [PTR_W-1:0]   seg,
    input  logic [PTR_W-1:0]   ptr,
    input  logic [IDX_W-1:0]   idx,
    input  logic               wide,
    output logic [2*PTR_W-1:0] addr
);
    localparam int AW = 2 * PTR_W;

    logic [AW-1:0] offset;

    // Scale the entry index by the slot size.
    always_comb begin
        offset = '0;
        if (wide) offset[IDX_W+1:2] = idx;
        else      offset[IDX_W:1]   = idx;
    end

    // Full-width add so a carry reaches the segment.
    always_comb addr = {seg, ptr} + offset;
endmodule

// File: rtl/rrf_ptr_step.sv
// Module: rrf_ptr_step
// Advances the read pointer by one descriptor, wraps it to the ring base
// at the ring limit, and compares the result with the write pointer.
// Assumes: a descriptor has ENTRIES slots of 2 or 4 bytes.
module rrf_ptr_step #(
    parameter int PTR_W   = 16,
    parameter int ENTRIES = 4
) (
    input  logic [PTR_W-1:0] rd_ptr,
    input  logic [PTR_W-1:0] base_ptr,
    input  logic [PTR_W-1:0] limit_ptr,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic             wide,
    output logic [PTR_W-1:0] next_ptr,
    output logic             exhaust
);
    localparam logic [PTR_W-1:0] STEP_NARROW = PTR_W'(ENTRIES * 2);
    localparam logic [PTR_W-1:0] STEP_WIDE   = PTR_W'(ENTRIES * 4);

    logic [PTR_W-1:0] advanced;

    // Step past the descriptor, modulo the pointer width.
    always_comb advanced = rd_ptr + (wide ? STEP_WIDE : STEP_NARROW);

    // Wrap at the limit, then test against the software pointer.
    always_comb begin
        next_ptr = (advanced == limit_ptr) ? base_ptr : advanced;
        exhaust  = (next_ptr == wr_ptr);
    end
endmodule

// File: rtl/rrf_word_bank.sv
// Module: rrf_word_bank
// Holds one captured word per descriptor entry; a write lands in the slot
// selected by the entry index.
// Assumes: synchronous active-low reset clears all slots.
module rrf_word_bank #(
    parameter int DW      = 16,
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [DW-1:0]         wr_data,
    output logic [ENTRIES*DW-1:0] words
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic [DW-1:0] q;

        // Capture the acknowledged word into its own slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                            q <= '0;
            else if (wr_en && wr_idx == IDX_W'(i)) q <= wr_data;
        end

        assign words[i*DW +: DW] = q;
    end
endmodule

// File: rtl/rx_resource_fetcher.sv
// Module: rx_resource_fetcher
// Sequences four single-word reads of a receive resource descriptor,
// exposes the fetched buffer address and word count, and produces the
// advanced read pointer with wrap and exhaustion status.
// Assumes: mem_addr is held until mem_ack; one ack per request; inputs
// are sampled only on the start edge.
module rx_resource_fetcher #(
    parameter int PTR_W   = 16,
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_go,
    input  logic [PTR_W-1:0]   seg_upper,
    input  logic [PTR_W-1:0]   ring_base,
    input  logic [PTR_W-1:0]   ring_limit,
    input  logic [PTR_W-1:0]   ring_rd,
    input  logic [PTR_W-1:0]   ring_wr,
    input  logic               wide_bus,
    output logic               mem_req,
    output logic [2*PTR_W-1:0] mem_addr,
    input  logic               mem_ack,
    input  logic [PTR_W-1:0]   mem_rdata,
    output logic [PTR_W-1:0]   buf_ptr_lo,
    output logic [PTR_W-1:0]   buf_ptr_hi,
    output logic [PTR_W-1:0]   buf_words_lo,
    output logic [PTR_W-1:0]   buf_words_hi,
    output logic [PTR_W-1:0]   rd_ptr_new,
    output logic               pool_exhausted,
    output logic               fetch_done,
    output logic               busy
);
    import rrf_pkg::*;

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    rrf_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [PTR_W-1:0] l_seg, l_base, l_limit, l_rd, l_wr;
    logic             l_wide;
    logic             take;
    logic             last_take;
    logic [PTR_W-1:0] step_ptr;
    logic             step_exh;
    logic [ENTRIES*PTR_W-1:0] words;

    // An acknowledged read and the final one.
    always_comb begin
        take      = (state == RRF_READ) && mem_ack;
        last_take = take && (idx == LAST_IDX);
    end

    // Control sequence: idle, reading entries, one done cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RRF_IDLE;
        end else begin
            unique case (state)
                RRF_IDLE: if (fetch_go)  state <= RRF_READ;
                RRF_READ: if (last_take) state <= RRF_DONE;
                RRF_DONE: state <= RRF_IDLE;
                default:  state <= RRF_IDLE;
            endcase
        end
    end

    // Entry counter: cleared on start, stepped per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  idx <= '0;
        else if (state == RRF_IDLE && fetch_go)      idx <= '0;
        else if (take && !last_take)                 idx <= idx + 1'b1;
    end

    // Latch the configuration only on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_seg   <= '0;
            l_base  <= '0;
            l_limit <= '0;
            l_rd    <= '0;
            l_wr    <= '0;
            l_wide  <= 1'b0;
        end else if (state == RRF_IDLE && fetch_go) begin
            l_seg   <= seg_upper;
            l_base  <= ring_base;
            l_limit <= ring_limit;
            l_rd    <= ring_rd;
            l_wr    <= ring_wr;
            l_wide  <= wide_bus;
        end
    end

    rrf_addr_gen #(
        .PTR_W (PTR_W),
        .IDX_W (IDX_W)
    ) u_addr (
        .seg  (l_seg),
        .ptr  (l_rd),
        .idx  (idx),
        .wide (l_wide),
        .addr (mem_addr)
    );

    rrf_ptr_step #(
        .PTR_W   (PTR_W),
        .ENTRIES (ENTRIES)
    ) u_step (
        .rd_ptr    (l_rd),
        .base_ptr  (l_base),
        .limit_ptr (l_limit),
        .wr_ptr    (l_wr),
        .wide      (l_wide),
        .next_ptr  (step_ptr),
        .exhaust   (step_exh)
    );

    rrf_word_bank #(
        .DW      (PTR_W),
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .wr_idx  (idx),
        .wr_data (mem_rdata),
        .words   (words)
    );

    // Commit pointer result and exhaustion on the final acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr_new     <= '0;
            pool_exhausted <= 1'b0;
        end else if (last_take) begin
            rd_ptr_new     <= step_ptr;
            pool_exhausted <= step_exh;
        end
    end

    // Map descriptor entries onto the named outputs.
    always_comb begin
        buf_ptr_lo   = words[0*PTR_W +: PTR_W];
        buf_ptr_hi   = words[1*PTR_W +: PTR_W];
        buf_words_lo = words[2*PTR_W +: PTR_W];
        buf_words_hi = words[3*PTR_W +: PTR_W];
    end

    // Handshake and status outputs decoded from the state.
    always_comb begin
        mem_req    = (state == RRF_READ);
        fetch_done = (state == RRF_DONE);
        busy       = (state != RRF_IDLE);
    end
endmodule

// File: rtl/rrf_sva.sv
// Module: rrf_sva
// Checker for rx_resource_fetcher handshake and sequencing; attached by bind.
module rrf_sva #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fetch_go,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          fetch_done,
    input logic          busy
);
    p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go && !busy |=> busy && mem_req);

    p_req_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !fetch_done);

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> busy && !mem_req);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> !busy);

    p_busy_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fetch_done |=> busy);
endmodule

bind rx_resource_fetcher rrf_sva #(.AW(2*PTR_W)) u_rrf_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_go   (fetch_go),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .fetch_done (fetch_done),
    .busy       (busy)
);

// File: tb/tb_rx_resource_fetcher.sv
// Bench for rx_resource_fetcher: random and directed fetches against a
// behavioural memory with random acknowledge delay.
module tb_rx_resource_fetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_go = 1'b0;
    logic [15:0] seg_upper = '0, ring_base = '0, ring_limit = '0;
    logic [15:0] ring_rd = '0, ring_wr = '0;
    logic        wide_bus = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [15:0] buf_ptr_lo, buf_ptr_hi, buf_words_lo, buf_words_hi;
    logic [15:0] rd_ptr_new;
    logic        pool_exhausted, fetch_done, busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rx_resource_fetcher dut (
        .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go),
        .seg_upper(seg_upper), .ring_base(ring_base), .ring_limit(ring_limit),
        .ring_rd(ring_rd), .ring_wr(ring_wr), .wide_bus(wide_bus),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .buf_ptr_lo(buf_ptr_lo), .buf_ptr_hi(buf_ptr_hi),
        .buf_words_lo(buf_words_lo), .buf_words_hi(buf_words_hi),
        .rd_ptr_new(rd_ptr_new), .pool_exhausted(pool_exhausted),
        .fetch_done(fetch_done), .busy(busy)
    );

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        return (a[15:0] * 16'd3) ^ {a[23:16], a[31:24]} ^ 16'hA5C3;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [15:0] s, input logic [15:0] p,
                                             input bit w, input int k);
        return {s, p} + 32'(k * (w ? 4 : 2));
    endfunction

    function automatic logic [15:0] exp_ptr(input logic [15:0] p, input logic [15:0] b,
                                            input logic [15:0] e, input bit w);
        logic [15:0] q;
        q = p + (w ? 16'd16 : 16'd8);
        return (q == e) ? b : q;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // One complete fetch; optionally disturbs inputs mid-flight.
    task automatic run_fetch(input logic [15:0] s, input logic [15:0] b,
                             input logic [15:0] e, input logic [15:0] p,
                             input logic [15:0] wp, input bit w, input bit disturb);
        logic [15:0] got [4];
        logic [15:0] ep;
        @(negedge clk);
        seg_upper = s; ring_base = b; ring_limit = e; ring_rd = p;
        ring_wr = wp; wide_bus = w; fetch_go = 1'b1;
        @(negedge clk);
        fetch_go = 1'b0;
        chk("R2 busy after start", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 4; k++) begin
            int d = $urandom_range(0, 3);
            for (int j = 0; j < d; j++) begin
                chk("R4 req held", {31'd0, mem_req}, 32'd1);
                chk("R4 addr held", mem_addr, exp_addr(s, p, w, k));
                @(negedge clk);
            end
            chk("R3 entry address", mem_addr, exp_addr(s, p, w, k));
            got[k] = mem_word(exp_addr(s, p, w, k));
            mem_ack = 1'b1;
            mem_rdata = got[k];
            @(negedge clk);
            mem_ack = 1'b0;
            mem_rdata = 16'hDEAD;
            if (disturb && k == 0) begin
                fetch_go = 1'b1;   // R10: must be ignored
                seg_upper = ~s; ring_base = ~b; ring_limit = ~e;
                ring_rd = ~p; ring_wr = ~wp; wide_bus = ~w;
            end
            if (disturb && k == 1) fetch_go = 1'b0;
        end
        chk("R9 done pulse", {31'd0, fetch_done}, 32'd1);
        chk("R9 busy at done", {31'd0, busy}, 32'd1);
        chk("R5 buf lo", {16'd0, buf_ptr_lo}, {16'd0, got[0]});
        chk("R5 buf hi", {16'd0, buf_ptr_hi}, {16'd0, got[1]});
        chk("R5 words lo", {16'd0, buf_words_lo}, {16'd0, got[2]});
        chk("R5 words hi", {16'd0, buf_words_hi}, {16'd0, got[3]});
        ep = exp_ptr(p, b, e, w);
        chk("R6 R7 new read pointer", {16'd0, rd_ptr_new}, {16'd0, ep});
        chk("R8 exhaustion", {31'd0, pool_exhausted}, {31'd0, ep == wp});
        @(negedge clk);
        chk("R9 idle after done", {30'd0, busy, fetch_done}, 32'd0);
        chk("R8 flag held", {31'd0, pool_exhausted}, {31'd0, ep == wp});
        if (disturb) chk("R10 no restart", {31'd0, mem_req}, 32'd0);
        seg_upper = s; ring_base = b; ring_limit = e;
        ring_rd = p; ring_wr = wp; wide_bus = w;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 reset controls", {29'd0, busy, fetch_done, mem_req}, 32'd0);
        chk("R1 reset outputs", {buf_ptr_lo ^ buf_ptr_hi ^ buf_words_lo ^ buf_words_hi,
                                 rd_ptr_new}, 32'd0);
        chk("R1 reset flag", {31'd0, pool_exhausted}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: R7 wrap, narrow
        run_fetch(16'h0040, 16'h1000, 16'h1040, 16'h1038, 16'h2000, 1'b0, 1'b0);
        // Directed: R7 wrap, wide, R8 exhaustion at wrapped value
        run_fetch(16'h0041, 16'h2000, 16'h2080, 16'h2070, 16'h2000, 1'b1, 1'b0);
        // Directed: R8 exhaustion without wrap
        run_fetch(16'h0100, 16'h0000, 16'h8000, 16'h0100, 16'h0108, 1'b0, 1'b0);
        // Directed: R6 16-bit roll-over, R3 carry into segment
        run_fetch(16'h7FFF, 16'h0000, 16'h4000, 16'hFFFC, 16'h1234, 1'b1, 1'b0);
        run_fetch(16'h1234, 16'h0000, 16'h4000, 16'hFFFA, 16'h0002, 1'b0, 1'b0);
        // Directed: R10 start and input changes during a fetch
        run_fetch(16'h0A0A, 16'h3000, 16'h3100, 16'h30F0, 16'h3000, 1'b1, 1'b1);
        // Random fetches
        for (int i = 0; i < 40; i++) begin
            logic [15:0] b, e, p, wp;
            bit w;
            w = 1'($urandom);
            b = 16'($urandom) & 16'hFFF0;
            e = b + 16'h0100;
            p = b + (16'($urandom_range(0, 15)) << 4);
            wp = (i % 4 == 0) ? exp_ptr(p, b, e, w) : 16'($urandom) & 16'hFFFE;
            run_fetch(16'($urandom), b, e, p, wp, w, (i % 5 == 0));
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule